// File: doc/BRIEF.md
# Processor Condition Code Register

This block holds the eight-bit condition code of a small accumulator-based processor. Five arithmetic flags (half carry, negative, zero, overflow, carry) are refreshed after each datapath operation. Which of them change depends on the class of the operation. Beside them sit two interrupt mask bits and a bit that forbids the stop instruction. The datapath reports an operation class and the ALU side signals. The sequencer pulses strobes for interrupt entry, for a return-from-interrupt restore and for a direct software write.

The block gates the two interrupt request lines with their mask bits. It also gates the stop request with the stop-disable bit. All of these interfaces are plain level or strobe signals, taken on every clock with no back-pressure: a strobe that is high at a rising edge always takes effect at that edge. Requests are not stored inside the block. Each one stays pending at its source while its mask is set, and reaches the output as soon as the mask clears.

Top module: `ccr_reg`

## Requirements
- R1: Bits from 7 down to 0 are S, X, H, I, N, Z, V, C. After reset the register reads 0xD0, which means S, X and I are set and all other bits are clear.
- R2: With alu_en high and alu_op = 1 (add class), H, N, Z, V and C are loaded at the clock edge. H takes alu_half, N takes the result MSB, Z is set when the result is all zeros, V takes alu_ovf and C takes alu_carry.
- R3: With alu_op = 2 (subtract or compare class), N, Z, V and C are loaded in the same way as for the add class, and H is left unchanged.
- R4: With alu_op = 3 (logic class), N and Z follow the result and V is cleared. C and H are left unchanged.
- R5: With alu_op = 4 (shift or rotate class), N and Z follow the result and C takes alu_shout. V becomes the exclusive OR of the new N and the new C. H is left unchanged.
- R6: With alu_op = 5 (index step class), only Z changes. It is set when idx_res is all zeros.
- R7: When alu_en is low, or alu_op is 0, 6 or 7, the flags do not change.
- R8: stop_ok is high only when stop_req is high and S is clear. When S is set, a stop request produces no output.
- R9: An int_entry pulse sets I at the edge and leaves every other bit unchanged.
- R10: An rti_load pulse loads the whole register from rti_data, and this includes setting X.
- R11: An sw_we pulse loads sw_data into the register, except for X. A software write can clear X but can never set it.
- R12: irq_go equals irq_req AND NOT I, and xirq_go equals xirq_req AND NOT X. A request held high while it is masked appears on the output once the mask bit is cleared.
- R13: When strobes arrive in the same cycle, rti_load overrides everything else. sw_we overrides the ALU update. int_entry sets I on top of the result of the software write or the ALU update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_en | input | 1 | ALU flag update strobe |
| alu_op | input | 3 | Operation class code |
| alu_res | input | DW | ALU result |
| alu_carry | input | 1 | Carry out or borrow |
| alu_half | input | 1 | Carry out of bit 3 |
| alu_ovf | input | 1 | Two's complement overflow |
| alu_shout | input | 1 | Bit shifted out by a shift or rotate |
| idx_res | input | IW | Index register result |
| int_entry | input | 1 | Interrupt entry, stacking done, before the vector fetch |
| rti_load | input | 1 | Restore strobe |
| rti_data | input | 8 | Unstacked register value |
| sw_we | input | 1 | Software write strobe |
| sw_data | input | 8 | Software write value |
| stop_req | input | 1 | Stop instruction decoded |
| irq_req | input | 1 | Maskable interrupt request |
| xirq_req | input | 1 | Pin interrupt request gated by X |
| ccr | output | 8 | Register contents |
| stop_ok | output | 1 | Stop is permitted |
| irq_go | output | 1 | Unmasked maskable request |
| xirq_go | output | 1 | Unmasked pin request |

## Verification
The hardest situations to reach are the ones where X must rise and where several strobes collide. Only a restore can raise X, so the stimulus first clears X through the restore path. It then tries to set X with a software write and checks that X stays clear. After that it raises X through the restore path. For the collision cases, the bench drives the restore, software-write, interrupt-entry and ALU strobes in the same cycle and reads the register back.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int CCR_W = 8;
  localparam int BIT_C = 0;
  localparam int BIT_V = 1;
  localparam int BIT_Z = 2;
  localparam int BIT_N = 3;
  localparam int BIT_I = 4;
  localparam int BIT_H = 5;
  localparam int BIT_X = 6;
  localparam int BIT_S = 7;
  localparam logic [CCR_W-1:0] CCR_RST = 8'hD0;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ADD   = 3'd1,
    OP_SUB   = 3'd2,
    OP_LOGIC = 3'd3,
    OP_SHIFT = 3'd4,
    OP_INDEX = 3'd5
  } op_e;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } arith_t;
endpackage

// File: rtl/ccr_flag_calc.sv
module ccr_flag_calc
  import ccr_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 16
) (
  input  logic          en,
  input  logic [2:0]    op,
  input  logic [DW-1:0] res,
  input  logic          carry,
  input  logic          half,
  input  logic          ovf,
  input  logic          shout,
  input  logic [IW-1:0] idx_res,
  input  arith_t        cur,
  output arith_t        nxt
);
  logic res_zero;
  logic res_neg;

  assign res_zero = (res == '0);
  assign res_neg  = res[DW-1];

  always_comb begin
    nxt = cur;
    if (en) begin
      case (op)
        OP_ADD: begin
          nxt.h = half;
          nxt.n = res_neg;
          nxt.z = res_zero;
          nxt.v = ovf;
          nxt.c = carry;
        end
        OP_SUB: begin
          nxt.n = res_neg;
          nxt.z = res_zero;
          nxt.v = ovf;
          nxt.c = carry;
        end
        OP_LOGIC: begin
          nxt.n = res_neg;
          nxt.z = res_zero;
          nxt.v = 1'b0;
        end
        OP_SHIFT: begin
          nxt.n = res_neg;
          nxt.z = res_zero;
          nxt.c = shout;
          nxt.v = res_neg ^ shout;
        end
        OP_INDEX: begin
          nxt.z = (idx_res == '0);
        end
        default: nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/ccr_mask_ctl.sv
module ccr_mask_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic s_bit,
  input  logic i_bit,
  input  logic x_bit,
  input  logic stop_req,
  input  logic irq_req,
  input  logic xirq_req,
  output logic stop_ok,
  output logic irq_go,
  output logic xirq_go
);
  assign stop_ok = stop_req & ~s_bit;
  assign irq_go  = irq_req  & ~i_bit;
  assign xirq_go = xirq_req & ~x_bit;

  // R8
  stop_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && s_bit) |-> !stop_ok);

  // R12
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (i_bit || x_bit) |-> !(irq_go && i_bit) && !(xirq_go && x_bit));
endmodule

// File: rtl/ccr_reg.sv
module ccr_reg
  import ccr_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alu_en,
  input  logic [2:0]       alu_op,
  input  logic [DW-1:0]    alu_res,
  input  logic             alu_carry,
  input  logic             alu_half,
  input  logic             alu_ovf,
  input  logic             alu_shout,
  input  logic [IW-1:0]    idx_res,
  input  logic             int_entry,
  input  logic             rti_load,
  input  logic [CCR_W-1:0] rti_data,
  input  logic             sw_we,
  input  logic [CCR_W-1:0] sw_data,
  input  logic             stop_req,
  input  logic             irq_req,
  input  logic             xirq_req,
  output logic [CCR_W-1:0] ccr,
  output logic             stop_ok,
  output logic             irq_go,
  output logic             xirq_go
);
  logic [CCR_W-1:0] q, d;
  arith_t cur, calc;

  assign cur = '{h: q[BIT_H], n: q[BIT_N], z: q[BIT_Z], v: q[BIT_V], c: q[BIT_C]};

  ccr_flag_calc #(.DW(DW), .IW(IW)) u_calc (
    .en(alu_en), .op(alu_op), .res(alu_res), .carry(alu_carry),
    .half(alu_half), .ovf(alu_ovf), .shout(alu_shout),
    .idx_res(idx_res), .cur(cur), .nxt(calc)
  );

  always_comb begin
    d = q;
    d[BIT_H] = calc.h;
    d[BIT_N] = calc.n;
    d[BIT_Z] = calc.z;
    d[BIT_V] = calc.v;
    d[BIT_C] = calc.c;
    if (sw_we) begin
      d = sw_data;
      d[BIT_X] = q[BIT_X] & sw_data[BIT_X];
    end
    if (int_entry) d[BIT_I] = 1'b1;
    if (rti_load) d = rti_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= CCR_RST;
    else        q <= d;
  end

  assign ccr = q;

  ccr_mask_ctl u_mask (
    .clk(clk), .rst_n(rst_n),
    .s_bit(q[BIT_S]), .i_bit(q[BIT_I]), .x_bit(q[BIT_X]),
    .stop_req(stop_req), .irq_req(irq_req), .xirq_req(xirq_req),
    .stop_ok(stop_ok), .irq_go(irq_go), .xirq_go(xirq_go)
  );

  // R3
  h_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rti_load && !sw_we && !(alu_en && alu_op == OP_ADD)) |=> $stable(ccr[BIT_H]));

  // R6
  idx_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && alu_op == OP_INDEX && !rti_load && !sw_we && !int_entry)
      |=> ($stable(ccr[7:3]) && $stable(ccr[1:0])));

  // R11
  x_norise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rti_load |=> !$rose(ccr[BIT_X]));

  // R9
  entry_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_entry && !rti_load) |=> ccr[BIT_I]);
endmodule

// File: tb/test_ccr_reg.sv
module test_ccr_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alu_en = 0;
  logic [2:0] alu_op = 0;
  logic [7:0] alu_res = 0;
  logic alu_carry = 0, alu_half = 0, alu_ovf = 0, alu_shout = 0;
  logic [15:0] idx_res = 16'h1;
  logic int_entry = 0, rti_load = 0, sw_we = 0;
  logic [7:0] rti_data = 0, sw_data = 0;
  logic stop_req = 0, irq_req = 0, xirq_req = 0;
  logic [7:0] ccr;
  logic stop_ok, irq_go, xirq_go;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  ccr_reg i_ccr_reg (
    .clk(clk), .rst_n(rst_n), .alu_en(alu_en), .alu_op(alu_op), .alu_res(alu_res),
    .alu_carry(alu_carry), .alu_half(alu_half), .alu_ovf(alu_ovf), .alu_shout(alu_shout),
    .idx_res(idx_res), .int_entry(int_entry), .rti_load(rti_load), .rti_data(rti_data),
    .sw_we(sw_we), .sw_data(sw_data), .stop_req(stop_req), .irq_req(irq_req),
    .xirq_req(xirq_req), .ccr(ccr), .stop_ok(stop_ok), .irq_go(irq_go), .xirq_go(xirq_go)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic clear_strobes();
    alu_en = 0; int_entry = 0; rti_load = 0; sw_we = 0;
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk); rti_load = 1; rti_data = v;
    @(negedge clk); clear_strobes();
  endtask

  task automatic alu(input logic [2:0] op, input logic [7:0] r, input logic c,
                     input logic h, input logic v, input logic sh, input logic [15:0] ix);
    @(negedge clk);
    alu_en = 1; alu_op = op; alu_res = r; alu_carry = c; alu_half = h;
    alu_ovf = v; alu_shout = sh; idx_res = ix;
    @(negedge clk); clear_strobes();
  endtask

  task automatic t_reset();
    stop_req = 1; irq_req = 1; xirq_req = 1;
    #1;
    chk("R1 reset value", ccr, 8'hD0);
    chk("R8 stop blocked after reset", {7'd0, stop_ok}, 8'd0);
    chk("R12 irq masked after reset", {6'd0, irq_go, xirq_go}, 8'd0);
    stop_req = 0; irq_req = 0; xirq_req = 0;
  endtask

  task automatic t_add();
    load(8'h00);
    alu(3'd1, 8'h80, 1, 1, 1, 0, 16'h1);
    chk("R2 add flags set", ccr, 8'h2B);
    alu(3'd1, 8'h00, 0, 0, 0, 0, 16'h1);
    chk("R2 add zero", ccr, 8'h04);
  endtask

  task automatic t_sub();
    load(8'h20);
    alu(3'd2, 8'h00, 1, 0, 0, 0, 16'h1);
    chk("R3 sub keeps H", ccr, 8'h25);
  endtask

  task automatic t_logic();
    load(8'h23);
    alu(3'd3, 8'h90, 0, 0, 1, 0, 16'h1);
    chk("R4 logic clears V keeps C", ccr, 8'h29);
  endtask

  task automatic t_shift();
    load(8'h00);
    alu(3'd4, 8'h40, 0, 0, 0, 1, 16'h1);
    chk("R5 shift V=N^C one", ccr, 8'h03);
    alu(3'd4, 8'h80, 0, 0, 0, 1, 16'h1);
    chk("R5 shift V=N^C zero", ccr, 8'h09);
  endtask

  task automatic t_index();
    load(8'h2B);
    alu(3'd5, 8'h00, 0, 1, 0, 0, 16'h0000);
    chk("R6 index zero", ccr, 8'h2F);
    alu(3'd5, 8'hFF, 1, 0, 1, 1, 16'h0005);
    chk("R6 index nonzero", ccr, 8'h2B);
  endtask

  task automatic t_idle();
    load(8'h15);
    @(negedge clk); alu_op = 3'd1; alu_res = 8'h00; alu_carry = 1; alu_half = 1;
    @(negedge clk);
    chk("R7 alu_en low", ccr, 8'h15);
    alu(3'd6, 8'h80, 1, 1, 1, 1, 16'h0);
    chk("R7 unused code", ccr, 8'h15);
  endtask

  task automatic t_stop();
    load(8'h80);
    stop_req = 1; #1;
    chk("R8 S set blocks stop", {7'd0, stop_ok}, 8'd0);
    load(8'h00); #1;
    chk("R8 S clear permits stop", {7'd0, stop_ok}, 8'd1);
    stop_req = 0; #1;
    chk("R8 no request", {7'd0, stop_ok}, 8'd0);
  endtask

  task automatic t_entry();
    load(8'h05);
    @(negedge clk); int_entry = 1;
    @(negedge clk); clear_strobes();
    chk("R9 entry sets I", ccr, 8'h15);
  endtask

  task automatic t_rti();
    load(8'h00);
    load(8'hFF);
    chk("R10 restore sets X", ccr, 8'hFF);
  endtask

  task automatic t_sw();
    load(8'h00);
    @(negedge clk); sw_we = 1; sw_data = 8'hFF;
    @(negedge clk); clear_strobes();
    chk("R11 write cannot set X", ccr, 8'hBF);
    load(8'h40);
    @(negedge clk); sw_we = 1; sw_data = 8'h00;
    @(negedge clk); clear_strobes();
    chk("R11 write clears X", ccr, 8'h00);
    load(8'h40);
    @(negedge clk); sw_we = 1; sw_data = 8'h40;
    @(negedge clk); clear_strobes();
    chk("R11 write keeps X", ccr, 8'h40);
  endtask

  task automatic t_irq();
    load(8'h50);
    irq_req = 1; xirq_req = 1; #1;
    chk("R12 both masked", {6'd0, irq_go, xirq_go}, 8'd0);
    @(negedge clk); sw_we = 1; sw_data = 8'h00;
    @(negedge clk); clear_strobes(); #1;
    chk("R12 pending requests released", {6'd0, irq_go, xirq_go}, 8'd3);
    load(8'h10); #1;
    chk("R12 only I masked", {6'd0, irq_go, xirq_go}, 8'd1);
    irq_req = 0; xirq_req = 0;
  endtask

  task automatic t_prio();
    load(8'h00);
    @(negedge clk);
    rti_load = 1; rti_data = 8'h81; sw_we = 1; sw_data = 8'h3F; int_entry = 1;
    alu_en = 1; alu_op = 3'd1; alu_res = 8'h00; alu_carry = 1;
    @(negedge clk); clear_strobes();
    chk("R13 restore wins", ccr, 8'h81);
    load(8'h00);
    @(negedge clk);
    sw_we = 1; sw_data = 8'h02; int_entry = 1;
    alu_en = 1; alu_op = 3'd1; alu_res = 8'h00; alu_carry = 1;
    @(negedge clk); clear_strobes();
    chk("R13 write over alu plus entry", ccr, 8'h12);
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_add();
    t_sub();
    t_logic();
    t_shift();
    t_index();
    t_idle();
    t_stop();
    t_entry();
    t_rti();
    t_sw();
    t_irq();
    t_prio();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule